// File: doc/BRIEF.md
# Interrupt Priority Register Bank

This block is the register file of a 32-line interrupt controller. Software reaches it over a plain word bus (byte offset, write data, write strobe, read strobe, read data). Through that bus it sets and clears the enable flag of each interrupt, raises or drops the pending flag of each interrupt, and programs a priority for each interrupt. The stored state drives three flat vectors toward an arbiter: one enable bit, one pending bit and one priority field per interrupt line.

Hardware interrupt request lines set pending flags on their rising edges. When the arbiter takes an interrupt, it presents the number of that interrupt on an acknowledge port, and the block clears that pending flag. The priority field is stored in the top bits of a byte. The interrupts are packed four to a 32-bit word. A priority write always replaces a whole word, so it updates four interrupts at once.

Top module: `intr_prio_regs`

## Requirements
- R1: After reset, every enable bit, pending bit and priority field is zero, and every mapped register reads back as zero.
- R2: A write to offset 0x100 sets the enable bit of each interrupt whose data bit is 1. Data bits of 0 leave the enable bits unchanged.
- R3: A write to offset 0x180 clears the enable bit of each interrupt whose data bit is 1. A read of 0x100 or of 0x180 returns the current enable vector, with bit n for interrupt n.
- R4: A write to offset 0x200 sets pending bits on written ones. A write to offset 0x280 clears pending bits on written ones. A read of either offset returns the current pending vector.
- R5: The priority of interrupt n lives in the word at offset 0x400 + 4*(n/4), at bits 8*(n%4)+7 down to 8*(n%4)+6. It appears on irq_prio[2n+1:2n].
- R6: In every priority byte, bits 5:0 always read back as zero, whatever value was written to them.
- R7: One write to a priority word replaces all four priority fields of that word in the same cycle.
- R8: A rising edge on irq_req[n] sets pending bit n in the next cycle. A line that stays high does not set the bit again after software has cleared it.
- R9: When a request edge and a software clear of the same pending bit fall in the same cycle, the pending bit ends up set.
- R10: A cycle with ack_valid high clears the pending bit of interrupt ack_id and leaves all other pending bits unchanged.
- R11: A read of an unmapped offset returns zero. A write to an unmapped offset changes no state.
- R12: bus_rdata is updated on the clock edge that samples bus_re high, and it holds its value in every other cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 12 | Byte offset of the access. Bits 1:0 are ignored. |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write strobe, one cycle per word write |
| bus_re | input | 1 | Read strobe |
| bus_rdata | output | 32 | Registered read data |
| irq_req | input | 32 | Hardware interrupt request lines |
| ack_valid | input | 1 | Arbiter acknowledge strobe |
| ack_id | input | 5 | Number of the interrupt being taken |
| irq_enable | output | 32 | Enable flag per interrupt |
| irq_pending | output | 32 | Pending flag per interrupt |
| irq_prio | output | 64 | Two-bit priority per interrupt, interrupt n at bits 2n+1:2n |

## Verification
The bench builds the block with its default values: 32 interrupt lines, two priority bits, and a 12-bit offset. With these values, all eight priority words, the full 32-bit flag vectors, and the top interrupt number 31 on the acknowledge port are exercised. Two priority bits leave a six-bit gap at the bottom of each byte. The bench writes ones into that gap to show that it reads back as zero. It also writes to offsets just past each mapped window, such as 0x104 and 0x420, which probes the decode boundaries.

// File: rtl/irb_pkg.sv
package irb_pkg;
   localparam int OFS_SET_EN  = 'h100;
   localparam int OFS_CLR_EN  = 'h180;
   localparam int OFS_SET_PND = 'h200;
   localparam int OFS_CLR_PND = 'h280;
   localparam int OFS_PRIO    = 'h400;

   typedef enum logic [2:0] {
      SEL_NONE,
      SEL_SET_EN,
      SEL_CLR_EN,
      SEL_SET_PND,
      SEL_CLR_PND,
      SEL_PRIO
   } irb_sel_e;
endpackage

// File: rtl/irb_decode.sv
module irb_decode
   import irb_pkg::*;
#(
   parameter int ADDR_W  = 12,
   parameter int NUM_REG = 8,
   parameter int IDX_W   = 3
) (
   input  logic [ADDR_W-1:0] addr,
   output irb_sel_e          sel,
   output logic [IDX_W-1:0]  idx
);
   localparam int WORD_W = ADDR_W - 2;
   localparam logic [WORD_W-1:0] W_SET_EN  = WORD_W'(OFS_SET_EN  >> 2);
   localparam logic [WORD_W-1:0] W_CLR_EN  = WORD_W'(OFS_CLR_EN  >> 2);
   localparam logic [WORD_W-1:0] W_SET_PND = WORD_W'(OFS_SET_PND >> 2);
   localparam logic [WORD_W-1:0] W_CLR_PND = WORD_W'(OFS_CLR_PND >> 2);
   localparam logic [WORD_W-1:0] W_PRIO    = WORD_W'(OFS_PRIO    >> 2);
   localparam logic [WORD_W-1:0] W_NREG    = WORD_W'(NUM_REG);

   logic [WORD_W-1:0] word;
   logic [WORD_W-1:0] rel;
   logic              unused_addr_lsb;

   assign word            = addr[ADDR_W-1:2];
   assign rel             = word - W_PRIO;
   assign unused_addr_lsb = ^addr[1:0];

   always_comb begin
      sel = SEL_NONE;
      idx = '0;
      if (word == W_SET_EN)       sel = SEL_SET_EN;
      else if (word == W_CLR_EN)  sel = SEL_CLR_EN;
      else if (word == W_SET_PND) sel = SEL_SET_PND;
      else if (word == W_CLR_PND) sel = SEL_CLR_PND;
      else if (word >= W_PRIO && rel < W_NREG) begin
         sel = SEL_PRIO;
         idx = rel[IDX_W-1:0];
      end
   end
endmodule

// File: rtl/irb_flag_bank.sv
module irb_flag_bank #(
   parameter int NUM_IRQ = 32,
   parameter int ID_W    = 5
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_IRQ-1:0] set_en,
   input  logic [NUM_IRQ-1:0] clr_en,
   input  logic [NUM_IRQ-1:0] set_pd,
   input  logic [NUM_IRQ-1:0] clr_pd,
   input  logic [NUM_IRQ-1:0] irq_req,
   input  logic               ack_valid,
   input  logic [ID_W-1:0]    ack_id,
   output logic [NUM_IRQ-1:0] en_q,
   output logic [NUM_IRQ-1:0] pd_q
);
   logic [NUM_IRQ-1:0] req_q;
   logic [NUM_IRQ-1:0] rise;
   logic [NUM_IRQ-1:0] ack_mask;
   logic [NUM_IRQ-1:0] drop;

   assign rise = irq_req & ~req_q;
   assign drop = (clr_pd | ack_mask) & ~rise;

   for (genvar i = 0; i < NUM_IRQ; i++) begin : g_ack
      assign ack_mask[i] = ack_valid && (ack_id == ID_W'(i));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         req_q <= '0;
         en_q  <= '0;
         pd_q  <= '0;
      end else begin
         req_q <= irq_req;
         en_q  <= (en_q | set_en) & ~clr_en;
         pd_q  <= (pd_q & ~drop) | set_pd | rise;
      end
   end

   assert_en_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (set_en == '0 && clr_en == '0) |=> $stable(en_q));

   assert_hw_edge_sets_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (|rise) |=> ((pd_q & $past(rise)) == $past(rise)));

   assert_edge_beats_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (|(rise & clr_pd)) |=> ((pd_q & $past(rise & clr_pd)) == $past(rise & clr_pd)));

   assert_ack_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_valid && !rise[ack_id] && !set_pd[ack_id]) |=> !pd_q[$past(ack_id)]);
endmodule

// File: rtl/irb_prio_bank.sv
module irb_prio_bank #(
   parameter int NUM_IRQ   = 32,
   parameter int PRIO_BITS = 2,
   parameter int IDX_W     = 3
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          we,
   input  logic [IDX_W-1:0]              idx,
   input  logic [31:0]                   wdata,
   output logic [NUM_IRQ*PRIO_BITS-1:0]  prio_flat,
   output logic [31:0]                   rd_word
);
   logic [PRIO_BITS-1:0] prio_q [NUM_IRQ];
   logic                 unused_wdata;

   assign unused_wdata = ^wdata;

   for (genvar n = 0; n < NUM_IRQ; n++) begin : g_field
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            prio_q[n] <= '0;
         else if (we && idx == IDX_W'(n / 4))
            prio_q[n] <= wdata[8*(n%4)+7 -: PRIO_BITS];
      end
      assign prio_flat[n*PRIO_BITS +: PRIO_BITS] = prio_q[n];
   end

   always_comb begin
      rd_word = '0;
      for (int l = 0; l < 4; l++)
         rd_word[8*l+7 -: PRIO_BITS] = prio_q[{idx, 2'(l)}];
   end

   assert_lane0_map_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (we && idx == '0) |=> (prio_q[0] == $past(wdata[7 -: PRIO_BITS])));

   assert_word_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (we && idx == '0) |=> (prio_q[3] == $past(wdata[31 -: PRIO_BITS])));
endmodule

// File: rtl/intr_prio_regs.sv
module intr_prio_regs
   import irb_pkg::*;
#(
   parameter int NUM_IRQ   = 32,
   parameter int PRIO_BITS = 2,
   parameter int ADDR_W    = 12,
   localparam int ID_W     = $clog2(NUM_IRQ),
   localparam int NUM_REG  = NUM_IRQ / 4,
   localparam int IDX_W    = $clog2(NUM_REG)
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic [ADDR_W-1:0]            bus_addr,
   input  logic [31:0]                  bus_wdata,
   input  logic                         bus_we,
   input  logic                         bus_re,
   output logic [31:0]                  bus_rdata,
   input  logic [NUM_IRQ-1:0]           irq_req,
   input  logic                         ack_valid,
   input  logic [ID_W-1:0]              ack_id,
   output logic [NUM_IRQ-1:0]           irq_enable,
   output logic [NUM_IRQ-1:0]           irq_pending,
   output logic [NUM_IRQ*PRIO_BITS-1:0] irq_prio
);
   if (NUM_IRQ % 4 != 0 || NUM_IRQ < 8 || NUM_IRQ > 32)
      $error("NUM_IRQ must be a multiple of 4 between 8 and 32");
   if (PRIO_BITS < 1 || PRIO_BITS > 8)
      $error("PRIO_BITS must lie between 1 and 8");
   if (ADDR_W < 11)
      $error("ADDR_W must reach the priority window");

   function automatic logic [31:0] low_mask();
      logic [31:0] m = '0;
      for (int b = 0; b < 32; b++)
         if ((b % 8) < 8 - PRIO_BITS) m[b] = 1'b1;
      return m;
   endfunction
   localparam logic [31:0] LOW_MASK = low_mask();

   irb_sel_e           sel;
   logic [IDX_W-1:0]   idx;
   logic [NUM_IRQ-1:0] wv;
   logic [NUM_IRQ-1:0] set_en, clr_en, set_pd, clr_pd;
   logic [31:0]        prio_rd;
   logic [31:0]        rd_mux;

   assign wv     = bus_wdata[NUM_IRQ-1:0];
   assign set_en = (bus_we && sel == SEL_SET_EN)  ? wv : '0;
   assign clr_en = (bus_we && sel == SEL_CLR_EN)  ? wv : '0;
   assign set_pd = (bus_we && sel == SEL_SET_PND) ? wv : '0;
   assign clr_pd = (bus_we && sel == SEL_CLR_PND) ? wv : '0;

   irb_decode #(.ADDR_W(ADDR_W), .NUM_REG(NUM_REG), .IDX_W(IDX_W)) u_dec (
      .addr (bus_addr),
      .sel  (sel),
      .idx  (idx)
   );

   irb_flag_bank #(.NUM_IRQ(NUM_IRQ), .ID_W(ID_W)) u_flags (
      .clk       (clk),
      .rst_n     (rst_n),
      .set_en    (set_en),
      .clr_en    (clr_en),
      .set_pd    (set_pd),
      .clr_pd    (clr_pd),
      .irq_req   (irq_req),
      .ack_valid (ack_valid),
      .ack_id    (ack_id),
      .en_q      (irq_enable),
      .pd_q      (irq_pending)
   );

   irb_prio_bank #(.NUM_IRQ(NUM_IRQ), .PRIO_BITS(PRIO_BITS), .IDX_W(IDX_W)) u_prio (
      .clk       (clk),
      .rst_n     (rst_n),
      .we        (bus_we && sel == SEL_PRIO),
      .idx       (idx),
      .wdata     (bus_wdata),
      .prio_flat (irq_prio),
      .rd_word   (prio_rd)
   );

   always_comb begin
      rd_mux = '0;
      case (sel)
         SEL_SET_EN, SEL_CLR_EN:   rd_mux[NUM_IRQ-1:0] = irq_enable;
         SEL_SET_PND, SEL_CLR_PND: rd_mux[NUM_IRQ-1:0] = irq_pending;
         SEL_PRIO:                 rd_mux = prio_rd;
         default:                  rd_mux = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      bus_rdata <= '0;
      else if (bus_re) bus_rdata <= rd_mux;
   end

   assert_unmapped_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_re && sel == SEL_NONE) |=> (bus_rdata == '0));

   assert_prio_low_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_re && sel == SEL_PRIO) |=> ((bus_rdata & LOW_MASK) == '0));

   assert_en_readback_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_re && (sel == SEL_SET_EN || sel == SEL_CLR_EN))
      |=> (bus_rdata[NUM_IRQ-1:0] == $past(irq_enable)));

   assert_rdata_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_re |=> $stable(bus_rdata));
endmodule

// File: tb/intr_prio_regs_tb.sv
module intr_prio_regs_tb_top;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [11:0] bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic        bus_we = 1'b0;
   logic        bus_re = 1'b0;
   logic [31:0] bus_rdata;
   logic [31:0] irq_req = '0;
   logic        ack_valid = 1'b0;
   logic [4:0]  ack_id = '0;
   logic [31:0] irq_enable;
   logic [31:0] irq_pending;
   logic [63:0] irq_prio;

   int n_cmp = 0;
   int n_bad = 0;

   logic [31:0] exp_q[$];
   string       tag_q[$];
   logic        rd_seen = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   intr_prio_regs dut_i (
      .clk, .rst_n, .bus_addr, .bus_wdata, .bus_we, .bus_re, .bus_rdata,
      .irq_req, .ack_valid, .ack_id, .irq_enable, .irq_pending, .irq_prio
   );

   // monitor: a read sampled at a posedge is compared at the following negedge
   always @(posedge clk) rd_seen <= bus_re;
   always @(negedge clk) begin
      if (rd_seen) begin
         if (exp_q.size() == 0) begin
            n_cmp++; n_bad++;
            $display("FAIL R12 unexpected read data act=%h exp=none", bus_rdata);
         end else begin
            logic [31:0] e;
            string       t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            n_cmp++;
            if (bus_rdata !== e) begin
               n_bad++;
               $display("FAIL %s read act=%h exp=%h", t, bus_rdata, e);
            end
         end
      end
   end

   task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s act=%h exp=%h", tag, act, exp);
      end
   endtask

   task automatic wr(logic [11:0] a, logic [31:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_we = 1'b1;
      @(negedge clk);
      bus_we = 1'b0;
   endtask

   task automatic rd(logic [11:0] a, logic [31:0] e, string tag);
      @(negedge clk);
      exp_q.push_back(e); tag_q.push_back(tag);
      bus_addr = a; bus_re = 1'b1;
      @(negedge clk);
      bus_re = 1'b0;
   endtask

   task automatic summary();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      n_cmp++; n_bad++;
      $display("FAIL watchdog act=running exp=finished");
      summary();
      $finish;
   end

   initial begin
      logic [31:0] exp_en;
      logic [31:0] exp_pd;
      logic [31:0] held;
      exp_en = '0; exp_pd = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      chk("R1 enable", {32'h0, irq_enable}, 64'h0);
      chk("R1 pending", {32'h0, irq_pending}, 64'h0);
      chk("R1 prio", irq_prio, 64'h0);
      rd(12'h100, 32'h0, "R1");
      rd(12'h280, 32'h0, "R1");
      rd(12'h41C, 32'h0, "R1");

      // R2 set-enable, zeros no effect
      wr(12'h100, 32'h0000_00F0); exp_en = 32'hF0;
      wr(12'h100, 32'h0000_0001); exp_en = 32'hF1;
      chk("R2 enable", {32'h0, irq_enable}, {32'h0, exp_en});
      // R3 clear-enable and both read offsets
      wr(12'h180, 32'h0000_0030); exp_en = 32'hC1;
      chk("R3 enable", {32'h0, irq_enable}, {32'h0, exp_en});
      rd(12'h100, exp_en, "R3");
      rd(12'h180, exp_en, "R3");

      // R4 set/clear pending
      wr(12'h200, 32'h8000_0004); exp_pd = 32'h8000_0004;
      chk("R4 pending", {32'h0, irq_pending}, {32'h0, exp_pd});
      rd(12'h280, exp_pd, "R4");
      wr(12'h280, 32'h0000_0004); exp_pd = 32'h8000_0000;
      rd(12'h200, exp_pd, "R4");

      // R5 R6 R7 priorities
      wr(12'h400, 32'hFFFF_FFFF);
      rd(12'h400, 32'hC0C0_C0C0, "R6");
      chk("R5 prio word0", irq_prio, 64'h0000_0000_0000_00FF);
      wr(12'h40C, 32'h4080_C000);
      rd(12'h40C, 32'h4080_C000, "R5");
      chk("R5 prio lanes", irq_prio, 64'h0000_0000_6C00_00FF);
      wr(12'h41C, 32'h3F3F_3F3F);
      rd(12'h41C, 32'h0, "R6");
      wr(12'h400, 32'h00C0_0000);
      chk("R7 word replace", irq_prio, 64'h0000_0000_6C00_0030);
      rd(12'h400, 32'h00C0_0000, "R7");

      // R8 hardware edge sets pending, held level does not re-set
      @(negedge clk); irq_req[5] = 1'b1;
      @(negedge clk); exp_pd = 32'h8000_0020;
      chk("R8 edge sets", {32'h0, irq_pending}, {32'h0, exp_pd});
      wr(12'h280, 32'h0000_0020); exp_pd = 32'h8000_0000;
      @(negedge clk);
      chk("R8 held level", {32'h0, irq_pending}, {32'h0, exp_pd});

      // R9 hardware edge beats software clear
      wr(12'h200, 32'h0000_0040); exp_pd = 32'h8000_0040;
      @(negedge clk);
      irq_req[6] = 1'b1;
      bus_addr = 12'h280; bus_wdata = 32'h0000_0040; bus_we = 1'b1;
      @(negedge clk);
      bus_we = 1'b0;
      chk("R9 edge wins", {32'h0, irq_pending}, {32'h0, exp_pd});
      irq_req = '0;

      // R10 acknowledge clears one pending bit
      @(negedge clk);
      ack_valid = 1'b1; ack_id = 5'd31;
      @(negedge clk);
      ack_valid = 1'b0; exp_pd = 32'h0000_0040;
      chk("R10 ack", {32'h0, irq_pending}, {32'h0, exp_pd});

      // R12 read data holds while other traffic runs
      rd(12'h100, exp_en, "R12");
      held = exp_en;
      wr(12'h100, 32'h0000_0002); exp_en = 32'hC3;
      @(negedge clk);
      chk("R12 hold", {32'h0, bus_rdata}, {32'h0, held});

      // R11 unmapped offsets
      wr(12'h104, 32'hFFFF_FFFF);
      wr(12'h300, 32'hFFFF_FFFF);
      wr(12'h420, 32'hFFFF_FFFF);
      wr(12'h000, 32'hFFFF_FFFF);
      chk("R11 enable kept", {32'h0, irq_enable}, {32'h0, exp_en});
      chk("R11 pending kept", {32'h0, irq_pending}, {32'h0, exp_pd});
      chk("R11 prio kept", irq_prio, 64'h0000_0000_6C00_0030);
      rd(12'h000, 32'h0, "R11");
      rd(12'h104, 32'h0, "R11");
      rd(12'h420, 32'h0, "R11");

      repeat (2) @(negedge clk);
      chk("R12 queue drained", 64'(exp_q.size()), 64'h0);
      summary();
      $finish;
   end
endmodule